// File: doc/BRIEF.md
# Scheduled-Pipeline Maximum Tree

This block takes a power-of-two number of unsigned words on one wide input bus and returns the largest of them. It does this with a binary tree. Each level pairs neighbouring results from the level beneath it and keeps the greater value of each pair, so every level halves the number of candidates. After the last level, one word remains.

A compile-time schedule vector, with one bit per level, decides where the tree holds its registers. A level whose bit is set captures its results on the rising clock edge. A level whose bit is clear is one layer of comparators with no flop. An integrator can therefore move between a fully combinational tree and a fully registered one, trading flops against clock rate, without editing the logic.

A valid flag travels next to the data and passes through the same registers. The output valid therefore marks the cycle in which the result belongs to the input word set captured earlier. The delay is the number of set bits in the schedule. It is available at elaboration through a package function, so the surrounding design can align its own signals to it.

Top module: `pipemax_tree`

## Requirements
- R1: The tree has 2**DEPTH leaves. Leaf k is the unsigned word at in_words[k*DATA_W +: DATA_W], and every leaf position, first and last included, takes part in the result.
- R2: When max_vld is high, max_o equals the largest unsigned input word of the word set the result belongs to, including the all-zero and all-ones cases.
- R3: When several leaves hold the same largest value, max_o reports that value.
- R4: Bit i of SCHED (bit 0 being the level that compares input pairs directly) registers level i+1. A single valid input reaches max_vld after exactly popcount(SCHED) rising edges.
- R5: max_vld equals in_vld delayed by popcount(SCHED) cycles, and max_o is the result for the input presented in that earlier cycle.
- R6: With SCHED all zeros, the path is purely combinational: max_vld follows in_vld, and max_o is the maximum of the current inputs within the same cycle.
- R7: A synchronous active-high rst clears every pipeline register and valid bit. When the schedule has at least one register, max_vld is low after reset, and inputs in flight when rst is sampled never produce a valid output.
- R8: The package function sched_latency(SCHED, DEPTH) returns popcount of the schedule, which is the cycle latency the block applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_words | input | 2**DEPTH * DATA_W | Packed unsigned leaf words, leaf 0 in the low bits |
| in_vld | input | 1 | Marks in_words as a word set to reduce |
| max_o | output | DATA_W | Largest leaf word |
| max_vld | output | 1 | Marks max_o as valid |

## Verification
The bench drives a registered instance (schedule 101, due two rising edges after the inputs are applied) and a combinational instance (schedule 000, due in the same cycle) from the same stimulus. Inputs change just after the falling edge. The registered outputs are sampled at the next falling edge, before new inputs are driven, and compared with the bench's record of the word set applied exactly popcount(SCHED) iterations earlier. The combinational outputs are sampled a short delay after the drive, within the same cycle. A reset in the middle of traffic marks the in-flight entries as flushed, so their slots must come out with valid low.

// File: rtl/pipemax_pkg.sv
package pipemax_pkg;

  // Number of register stages implied by a per-level schedule.
  function automatic int sched_latency(input logic [31:0] sched, input int depth);
    int n;
    n = 0;
    for (int i = 0; i < depth; i++) begin
      if (sched[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/pipemax_node.sv
module pipemax_node #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  // Unsigned compare; on a tie the left operand is forwarded.
  assign y = (a >= b) ? a : b;

endmodule

// File: rtl/pipemax_level.sv
module pipemax_level #(
  parameter int DATA_W = 8,
  parameter int N_IN   = 2,
  parameter bit REG    = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_IN*DATA_W-1:0]     in_bus,
  input  logic                       in_vld,
  output logic [(N_IN/2)*DATA_W-1:0] out_bus,
  output logic                       out_vld
);

  localparam int N_OUT = N_IN / 2;

  logic [N_OUT*DATA_W-1:0] cmp;

  for (genvar j = 0; j < N_OUT; j++) begin : g_node
    pipemax_node #(.DATA_W(DATA_W)) u_node (
      .a (in_bus[(2*j)*DATA_W +: DATA_W]),
      .b (in_bus[(2*j+1)*DATA_W +: DATA_W]),
      .y (cmp[j*DATA_W +: DATA_W])
    );
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_bus <= '0;
        out_vld <= 1'b0;
      end else begin
        out_bus <= cmp;
        out_vld <= in_vld;
      end
    end
  end else begin : g_comb
    logic unused_clkrst;
    assign unused_clkrst = clk ^ rst;
    assign out_bus = cmp;
    assign out_vld = in_vld;
  end

endmodule

// File: rtl/pipemax_tree.sv
module pipemax_tree #(
  parameter int               DATA_W = 8,
  parameter int               DEPTH  = 3,
  parameter logic [DEPTH-1:0] SCHED  = 3'b101
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [(1<<DEPTH)*DATA_W-1:0]   in_words,
  input  logic                           in_vld,
  output logic [DATA_W-1:0]              max_o,
  output logic                           max_vld
);

  localparam int LEAVES = 1 << DEPTH;
  localparam int LAT    = pipemax_pkg::sched_latency(32'(SCHED), DEPTH);

  for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
    localparam int N_IN = LEAVES >> (l - 1);

    logic [N_IN*DATA_W-1:0]     d;
    logic                       dv;
    logic [(N_IN/2)*DATA_W-1:0] q;
    logic                       qv;

    if (l == 1) begin : g_src_in
      assign d  = in_words;
      assign dv = in_vld;
    end else begin : g_src_prev
      assign d  = g_lvl[l-1].q;
      assign dv = g_lvl[l-1].qv;
    end

    pipemax_level #(
      .DATA_W (DATA_W),
      .N_IN   (N_IN),
      .REG    (SCHED[l-1])
    ) u_level (
      .clk     (clk),
      .rst     (rst),
      .in_bus  (d),
      .in_vld  (dv),
      .out_bus (q),
      .out_vld (qv)
    );
  end

  assign max_o   = g_lvl[DEPTH].q;
  assign max_vld = g_lvl[DEPTH].qv;

  initial begin
    if (DEPTH < 1 || DEPTH > 31) $error("pipemax_tree: DEPTH out of range");
    if (LAT > DEPTH) $error("pipemax_tree: bad latency");
  end

endmodule

// File: rtl/pipemax_chk.sv
module pipemax_chk #(
  parameter int               DATA_W = 8,
  parameter int               DEPTH  = 3,
  parameter logic [DEPTH-1:0] SCHED  = 3'b101
) (
  input logic                         clk,
  input logic                         rst,
  input logic [(1<<DEPTH)*DATA_W-1:0] in_words,
  input logic                         in_vld,
  input logic [DATA_W-1:0]            max_o,
  input logic                         max_vld
);

  localparam int LEAVES = 1 << DEPTH;
  localparam int LAT    = pipemax_pkg::sched_latency(32'(SCHED), DEPTH);

  logic [LEAVES*DATA_W-1:0] tap_words;
  logic                     tap_vld;

  if (LAT == 0) begin : g_tap_now
    assign tap_words = in_words;
    assign tap_vld   = in_vld;
  end else begin : g_tap_dly
    logic [LEAVES*DATA_W-1:0] dly_w [LAT];
    logic [LAT-1:0]           dly_v;
    always_ff @(posedge clk) begin
      dly_w[0] <= in_words;
      for (int k = 1; k < LAT; k++) dly_w[k] <= dly_w[k-1];
      if (rst) dly_v <= '0;
      else     dly_v <= {dly_v[LAT-2 >= 0 ? LAT-2 : 0 : 0], in_vld} & {LAT{1'b1}};
    end
    assign tap_words = dly_w[LAT-1];
    assign tap_vld   = dly_v[LAT-1];
  end

  function automatic bit none_above(input logic [LEAVES*DATA_W-1:0] w, input logic [DATA_W-1:0] m);
    for (int k = 0; k < LEAVES; k++) if (w[k*DATA_W +: DATA_W] > m) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit is_member(input logic [LEAVES*DATA_W-1:0] w, input logic [DATA_W-1:0] m);
    for (int k = 0; k < LEAVES; k++) if (w[k*DATA_W +: DATA_W] == m) return 1'b1;
    return 1'b0;
  endfunction

  // R5: output valid tracks input valid shifted by the schedule latency
  assert_vld_align_R5: assert property (@(posedge clk) disable iff (rst)
    max_vld == tap_vld);

  // R2: no leaf of the matching word set exceeds the reported maximum
  assert_max_bound_R2: assert property (@(posedge clk) disable iff (rst)
    max_vld |-> none_above(tap_words, max_o));

  // R3: the reported maximum is one of the leaf values (ties included)
  assert_max_member_R3: assert property (@(posedge clk) disable iff (rst)
    max_vld |-> is_member(tap_words, max_o));

  if (LAT > 0) begin : g_flush
    // R7: the cycle after a reset never shows a valid result
    assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !max_vld);
  end

endmodule

bind pipemax_tree pipemax_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .SCHED  (SCHED)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_words (in_words),
  .in_vld   (in_vld),
  .max_o    (max_o),
  .max_vld  (max_vld)
);

// File: tb/pipemax_tree_test.sv
module pipemax_tree_test;

  localparam int         DATA_W  = 8;
  localparam int         DEPTH   = 3;
  localparam int         LEAVES  = 1 << DEPTH;
  localparam logic [2:0] SCHED_P = 3'b101;
  localparam int         HSZ     = 16;

  function automatic int bench_pop(input logic [2:0] s);
    int n = 0;
    for (int i = 0; i < 3; i++) n += int'(s[i]);
    return n;
  endfunction

  localparam int LAT_P = bench_pop(SCHED_P);

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [LEAVES*DATA_W-1:0] in_words = '0;
  logic                     in_vld = 1'b0;
  logic [DATA_W-1:0]        max_p, max_c;
  logic                     vld_p, vld_c;

  always #2 clk = ~clk;

  pipemax_tree #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SCHED(SCHED_P)) uut (
    .clk(clk), .rst(rst), .in_words(in_words), .in_vld(in_vld),
    .max_o(max_p), .max_vld(vld_p));

  pipemax_tree #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SCHED(3'b000)) uut_comb (
    .clk(clk), .rst(rst), .in_words(in_words), .in_vld(in_vld),
    .max_o(max_c), .max_vld(vld_c));

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int pulse_at = -1, seen_at = -1;
  bit done = 1'b0;

  logic [LEAVES*DATA_W-1:0] h_words [HSZ];
  logic                     h_vld   [HSZ];
  logic                     h_flush [HSZ];
  string                    h_tag   [HSZ];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] ref_max(input logic [LEAVES*DATA_W-1:0] w);
    logic [DATA_W-1:0] m = '0;
    for (int k = 0; k < LEAVES; k++)
      if (w[k*DATA_W +: DATA_W] > m) m = w[k*DATA_W +: DATA_W];
    return m;
  endfunction

  task automatic step(input logic [LEAVES*DATA_W-1:0] w, input logic v, input logic r, input string tag);
    int    src;
    logic  ev;
    string vtag;
    @(negedge clk);
    src = cyc - LAT_P;
    ev  = 1'b0;
    vtag = "R5";
    if (src >= 0) begin
      ev = h_vld[src % HSZ];
      if (h_flush[src % HSZ]) vtag = "R7";
    end
    check(vld_p === ev, vtag, longint'(vld_p), longint'(ev));
    if (ev === 1'b1)
      check(max_p === ref_max(h_words[src % HSZ]), h_tag[src % HSZ],
            longint'(max_p), longint'(ref_max(h_words[src % HSZ])));
    if (pulse_at >= 0 && seen_at < 0 && vld_p === 1'b1) seen_at = cyc;
    rst = r; in_words = w; in_vld = v;
    if (r) begin
      for (int k = 0; k < HSZ; k++) begin
        if (h_vld[k]) h_flush[k] = 1'b1;
        h_vld[k] = 1'b0;
      end
    end
    h_words[cyc % HSZ] = w;
    h_vld[cyc % HSZ]   = v & ~r;
    h_flush[cyc % HSZ] = 1'b0;
    h_tag[cyc % HSZ]   = tag;
    #1;
    check(vld_c === v, "R6", longint'(vld_c), longint'(v));
    if (v) check(max_c === ref_max(w), "R6", longint'(max_c), longint'(ref_max(w)));
    cyc++;
  endtask

  function automatic logic [LEAVES*DATA_W-1:0] rand_words(input logic [DATA_W-1:0] mask);
    logic [LEAVES*DATA_W-1:0] w;
    for (int k = 0; k < LEAVES; k++) w[k*DATA_W +: DATA_W] = DATA_W'($urandom) & mask;
    return w;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LEAVES*DATA_W-1:0] w;
    void'($urandom(32'd2024));
    for (int k = 0; k < HSZ; k++) begin
      h_vld[k] = 1'b0; h_flush[k] = 1'b0; h_words[k] = '0; h_tag[k] = "R2";
    end

    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b0, "R2");
    // R7: reset state of the registered instance
    check(vld_p === 1'b0, "R7", longint'(vld_p), 0);

    // R8: elaboration-time latency matches the schedule popcount
    check(pipemax_pkg::sched_latency(32'(SCHED_P), DEPTH) == LAT_P, "R8",
          pipemax_pkg::sched_latency(32'(SCHED_P), DEPTH), LAT_P);

    // R1: large value at every leaf position in turn
    for (int k = 0; k < LEAVES; k++) begin
      w = {LEAVES{8'h10}};
      w[k*DATA_W +: DATA_W] = 8'hC0 + 8'(k);
      step(w, 1'b1, 1'b0, "R1");
    end

    // R3: ties
    step({LEAVES{8'h55}}, 1'b1, 1'b0, "R3");
    w = {LEAVES{8'h03}};
    w[2*DATA_W +: DATA_W] = 8'hA7;
    w[5*DATA_W +: DATA_W] = 8'hA7;
    step(w, 1'b1, 1'b0, "R3");

    // R2: extremes
    step('0, 1'b1, 1'b0, "R2");
    step({LEAVES{8'hFF}}, 1'b1, 1'b0, "R2");
    w = '0; w[7*DATA_W +: DATA_W] = 8'h01;
    step(w, 1'b1, 1'b0, "R2");

    // R4: single pulse latency
    for (int i = 0; i < LAT_P + 2; i++) step('0, 1'b0, 1'b0, "R2");
    pulse_at = cyc;
    step({LEAVES{8'h21}}, 1'b1, 1'b0, "R4");
    for (int i = 0; i < LAT_P + 3; i++) step('0, 1'b0, 1'b0, "R2");
    check(seen_at - pulse_at == LAT_P, "R4", seen_at - pulse_at, LAT_P);

    // R5: random traffic, some with narrow values to force ties
    for (int i = 0; i < 400; i++) begin
      logic [DATA_W-1:0] mask;
      mask = ($urandom % 4 == 0) ? 8'h03 : 8'hFF;
      step(rand_words(mask), ($urandom % 4) != 0, 1'b0, "R5");
    end

    // R7: reset with results in flight
    step(rand_words(8'hFF), 1'b1, 1'b0, "R7");
    step(rand_words(8'hFF), 1'b1, 1'b0, "R7");
    step('0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < LAT_P + 2; i++) step('0, 1'b0, 1'b0, "R7");
    step(rand_words(8'hFF), 1'b1, 1'b0, "R7");
    for (int i = 0; i < LAT_P + 2; i++) step('0, 1'b0, 1'b0, "R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule